// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Line Refill

This block is a read-only, direct-mapped cache that sits between a processor load port and a slower backing memory. A 32-bit byte address is split into a tag, a line index, a word offset within the line and a byte offset within the word. The parameters are the number of lines and the number of 32-bit words per line. Each line keeps a tag, a valid flag and its data words in registers. With the default of 256 lines of 16 words, the data store is 16 KB. Each line then holds 512 data bits, an 18-bit tag and one valid bit, for 135,936 storage bits in total.

A lookup decides hit or miss in the cycle the request is accepted. It uses one equality compare: the stored valid flag is placed above the stored tag, and a constant one is placed above the address tag. On a hit, the addressed word comes back on the next cycle. On a miss, the block stops taking requests and raises a refill request carrying the line-aligned address. It then takes the line one word per beat in ascending order. When the line is complete, it returns the requested word and marks the line valid under the new tag. A refilled line always replaces whatever was held at its index.

Top module: `dmc_cache`

## Requirements
- R1: The byte address splits, from bit 0 upward, into a 2-bit byte select (ignored), a word offset of log2(WORDS) bits, an index of log2(LINES) bits and a tag made of the remaining bits. The defaults give 2, 4, 8 and 18 bits. With 4 lines of 4 words, word-address bits [1:0] pick the word and bits [3:2] pick the line.
- R2: Reset clears every valid flag. After reset `req_ready` is 1, and `resp_valid` and `fill_req` are 0. The first access to any line after reset misses.
- R3: A hit requires `{valid, stored_tag} == {1, address_tag}` across the full tag width. On the cycle after a hit is accepted, `resp_valid`=1, `resp_hit`=1 and `resp_data` is the addressed word.
- R4: On the cycle after a miss is accepted, `fill_req`=1, `req_ready`=0 and `resp_valid`=0. `fill_line_addr` holds the requested address with the word-offset and byte bits cleared, and it stays unchanged while `fill_req` is high.
- R5: Refill data arrives on `fill_data` in ascending word order, one word per cycle in which `fill_valid` is 1. Cycles without `fill_valid` only stall. `fill_req` stays high until the last word is taken and is 0 afterwards.
- R6: On the cycle after the last refill word, `resp_valid`=1, `resp_hit`=0, `resp_data` is the requested word and `req_ready`=1.
- R7: Placement is direct mapped. A refill overwrites the line at its index, and a later access to the evicted tag misses. Over the word-address sequence 2, 3, 11, 16, 21, 13, 64, 48, 19, 11, 3, 22, 4, 27, 6, 11 with 4 lines of 4 words, exactly 4 accesses hit.
- R8: A request issued in the same cycle a miss response is shown, to the line just refilled, hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request; accepted when `req_ready` is 1 |
| req_addr | input | 32 | Byte address of the requested word |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | One-cycle pulse carrying a response |
| resp_hit | output | 1 | Response came from a hit (1) or a refill (0) |
| resp_data | output | 32 | Requested word |
| fill_req | output | 1 | Refill in progress; line wanted from memory |
| fill_line_addr | output | 32 | Line-aligned byte address to refill |
| fill_valid | input | 1 | One refill word presented this cycle |
| fill_data | input | 32 | Refill word, lowest offset first |

## Verification
The completion of a refill and the acceptance of the next lookup can fall in the same cycle. The miss response is shown in the very cycle in which `req_ready` returns, so the next request may be accepted while the freshly written tag, valid flag and data are first visible to the compare. The bench provokes this by issuing each access back to back with the previous response, including same-line pairs such as word 2 followed by word 3. The behavioural model predicts a hit from its own line table, and the returned word must equal the memory pattern for that address. A gap in the refill beats also checks that a stalled refill leaves the line address and the stall unchanged.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned BYTE_SEL_W = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_FILL = 1'b1
    } ctl_state_e;

    // Hit test: valid flag on top of the stored tag against a constant one
    // on top of the address tag, folded into one equality.
    function automatic logic tag_match(input logic v, input logic [ADDR_W-1:0] stored,
                                       input logic [ADDR_W-1:0] wanted);
        return {v, stored} == {1'b1, wanted};
    endfunction

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
#(
    parameter int unsigned LINES = 256,
    parameter int unsigned IDX_W = 8,
    parameter int unsigned TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign hit = tag_match(valid_q[rd_idx], ADDR_W'(tag_q[rd_idx]), ADDR_W'(rd_tag));

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
#(
    parameter int unsigned DEPTH = 4096,
    parameter int unsigned AW    = 12
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  word_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_data
);

    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/dmc_fill_ctrl.sv
module dmc_fill_ctrl
    import dmc_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned OFF_W = 4,
    parameter int unsigned TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [OFF_W-1:0] req_off,
    input  logic             lookup_hit,
    input  word_t            lookup_word,
    input  logic             fill_valid,
    input  word_t            fill_data,
    output logic             req_ready,
    output logic             fill_req,
    output addr_t            fill_line_addr,
    output logic             dwr_en,
    output logic [IDX_W+OFF_W-1:0] dwr_addr,
    output word_t            dwr_data,
    output logic             twr_en,
    output logic [IDX_W-1:0] twr_idx,
    output logic [TAG_W-1:0] twr_tag,
    output logic             resp_valid,
    output logic             resp_hit,
    output word_t            resp_data
);

    localparam logic [OFF_W-1:0] LAST_BEAT = '1;

    ctl_state_e       state_q;
    logic [TAG_W-1:0] tag_q;
    logic [IDX_W-1:0] idx_q;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] beat_q;
    word_t            cap_q;
    logic             last_beat;

    assign last_beat = (state_q == CS_FILL) && fill_valid && (beat_q == LAST_BEAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CS_IDLE;
            tag_q      <= '0;
            idx_q      <= '0;
            off_q      <= '0;
            beat_q     <= '0;
            cap_q      <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (state_q == CS_IDLE) begin
                if (req_valid) begin
                    tag_q <= req_tag;
                    idx_q <= req_idx;
                    off_q <= req_off;
                    if (lookup_hit) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_data  <= lookup_word;
                    end else begin
                        state_q <= CS_FILL;
                        beat_q  <= '0;
                    end
                end
            end else if (fill_valid) begin
                beat_q <= beat_q + 1'b1;
                if (beat_q == off_q) begin
                    cap_q <= fill_data;
                end
                if (beat_q == LAST_BEAT) begin
                    state_q    <= CS_IDLE;
                    resp_valid <= 1'b1;
                    resp_hit   <= 1'b0;
                    resp_data  <= (off_q == LAST_BEAT) ? fill_data : cap_q;
                end
            end
        end
    end

    assign req_ready      = (state_q == CS_IDLE);
    assign fill_req       = (state_q == CS_FILL);
    assign fill_line_addr = {tag_q, idx_q, {(OFF_W + BYTE_SEL_W){1'b0}}};
    assign dwr_en         = (state_q == CS_FILL) && fill_valid;
    assign dwr_addr       = {idx_q, beat_q};
    assign dwr_data       = fill_data;
    assign twr_en         = last_beat;
    assign twr_idx        = idx_q;
    assign twr_tag        = tag_q;

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int unsigned LINES = 256,
    parameter int unsigned WORDS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    output logic        req_ready,
    output logic        resp_valid,
    output logic        resp_hit,
    output logic [31:0] resp_data,
    output logic        fill_req,
    output logic [31:0] fill_line_addr,
    input  logic        fill_valid,
    input  logic [31:0] fill_data
);

    localparam int unsigned OFF_W = $clog2(WORDS);
    localparam int unsigned IDX_W = $clog2(LINES);
    localparam int unsigned TAG_W = ADDR_W - BYTE_SEL_W - OFF_W - IDX_W;
    localparam int unsigned SLOTS = LINES * WORDS;
    localparam int unsigned SLOT_W = IDX_W + OFF_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
        logic [BYTE_SEL_W-1:0] bsel;
    } addr_split_t;

    addr_split_t req_f;
    logic        unused_bsel;
    logic        lookup_hit;
    word_t       lookup_word;
    logic        dwr_en;
    logic [SLOT_W-1:0] dwr_addr;
    word_t       dwr_data;
    logic        twr_en;
    logic [IDX_W-1:0] twr_idx;
    logic [TAG_W-1:0] twr_tag;

    assign req_f       = addr_split_t'(req_addr);
    assign unused_bsel = ^req_f.bsel;

    dmc_tag_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) i_tags (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (req_f.idx),
        .rd_tag (req_f.tag),
        .hit    (lookup_hit),
        .wr_en  (twr_en),
        .wr_idx (twr_idx),
        .wr_tag (twr_tag)
    );

    dmc_data_store #(
        .DEPTH (SLOTS),
        .AW    (SLOT_W)
    ) i_data (
        .clk     (clk),
        .wr_en   (dwr_en),
        .wr_addr (dwr_addr),
        .wr_data (dwr_data),
        .rd_addr ({req_f.idx, req_f.off}),
        .rd_data (lookup_word)
    );

    dmc_fill_ctrl #(
        .IDX_W (IDX_W),
        .OFF_W (OFF_W),
        .TAG_W (TAG_W)
    ) i_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_tag        (req_f.tag),
        .req_idx        (req_f.idx),
        .req_off        (req_f.off),
        .lookup_hit     (lookup_hit),
        .lookup_word    (lookup_word),
        .fill_valid     (fill_valid),
        .fill_data      (fill_data),
        .req_ready      (req_ready),
        .fill_req       (fill_req),
        .fill_line_addr (fill_line_addr),
        .dwr_en         (dwr_en),
        .dwr_addr       (dwr_addr),
        .dwr_data       (dwr_data),
        .twr_en         (twr_en),
        .twr_idx        (twr_idx),
        .twr_tag        (twr_tag),
        .resp_valid     (resp_valid),
        .resp_hit       (resp_hit),
        .resp_data      (resp_data)
    );

endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        lookup_hit,
    input logic        resp_valid,
    input logic        resp_hit,
    input logic        fill_req,
    input logic        fill_valid,
    input logic [31:0] fill_line_addr
);

    AST_HIT_ANSWERS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && lookup_hit) |=> (resp_valid && resp_hit)); // R3

    AST_MISS_OPENS_FILL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !lookup_hit) |=> (fill_req && !req_ready && !resp_valid)); // R4

    AST_FILL_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> (!fill_req || $stable(fill_line_addr))); // R4

    AST_MISS_RESP_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> $past(fill_req && fill_valid)); // R6

    AST_MISS_RESP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> (req_ready && !fill_req)); // R5

endmodule

bind dmc_cache dmc_cache_chk i_dmc_cache_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .lookup_hit     (lookup_hit),
    .resp_valid     (resp_valid),
    .resp_hit       (resp_hit),
    .fill_req       (fill_req),
    .fill_valid     (fill_valid),
    .fill_line_addr (fill_line_addr)
);

// File: tb/test_dmc_cache.sv
`timescale 1ns/1ps
module test_dmc_cache;

    localparam int LINES = 4;
    localparam int WORDS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic        resp_hit;
    logic [31:0] resp_data;
    logic        fill_req;
    logic [31:0] fill_line_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int checks = 0;
    int fails = 0;
    int hits = 0;
    bit          ref_valid [int];
    int unsigned ref_tag [int];

    always #10 clk = ~clk;

    dmc_cache #(.LINES(LINES), .WORDS(WORDS)) i_dmc_cache (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_data(resp_data), .fill_req(fill_req), .fill_line_addr(fill_line_addr),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] wa);
        return 32'h5A00_0000 ^ (wa * 32'h0001_0003) ^ (wa >> 7);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-clock protocol comparison: a refill in progress never accepts requests.
    always @(negedge clk) begin
        if (!rst && fill_req === 1'b1)
            check(req_ready === 1'b0, "R4", "ready during refill", {31'd0, req_ready}, 32'd0);
    end

    task automatic access(input logic [31:0] wa, input logic [1:0] bsel, output bit was_hit);
        int          idx = int'((wa / WORDS) % LINES);
        int unsigned tag = wa / (WORDS * LINES);
        logic [31:0] off = wa % WORDS;
        logic [31:0] base = wa - off;
        bit exp_hit = ref_valid.exists(idx) && ref_tag[idx] == tag;
        check(req_ready === 1'b1, "R6", "ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_addr  = {wa[29:0], bsel};
        @(negedge clk);
        req_valid = 1'b0;
        was_hit = exp_hit;
        if (exp_hit) begin
            hits++;
            check(resp_valid === 1'b1 && resp_hit === 1'b1, "R3", "hit response",
                  {30'd0, resp_valid, resp_hit}, 32'd3);
            check(resp_data === mem_word(wa), "R1 R3", "hit data", resp_data, mem_word(wa));
        end else begin
            check(resp_valid === 1'b0 && fill_req === 1'b1 && req_ready === 1'b0, "R4",
                  "miss opens refill", {29'd0, resp_valid, fill_req, req_ready}, 32'd2);
            check(fill_line_addr === (base << 2), "R1 R4", "line address",
                  fill_line_addr, base << 2);
            for (int k = 0; k < WORDS; k++) begin
                if (k == 2) begin
                    fill_valid = 1'b0;
                    @(negedge clk);
                    check(fill_req === 1'b1 && fill_line_addr === (base << 2), "R5",
                          "stalled refill held", fill_line_addr, base << 2);
                end
                fill_valid = 1'b1;
                fill_data  = mem_word(base + 32'(k));
                @(negedge clk);
            end
            fill_valid = 1'b0;
            check(fill_req === 1'b0, "R5", "refill done", {31'd0, fill_req}, 32'd0);
            check(resp_valid === 1'b1 && resp_hit === 1'b0 && req_ready === 1'b1, "R6",
                  "miss response", {29'd0, resp_valid, resp_hit, req_ready}, 32'd5);
            check(resp_data === mem_word(wa), "R1 R6", "miss data", resp_data, mem_word(wa));
            ref_valid[idx] = 1'b1;
            ref_tag[idx]   = tag;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R5 watchdog actual=%0d expected=%0d", 50000, 0);
        finish_run();
    end

    initial begin
        int seq [16] = '{2, 3, 11, 16, 21, 13, 64, 48, 19, 11, 3, 22, 4, 27, 6, 11};
        bit h;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(req_ready === 1'b1 && resp_valid === 1'b0 && fill_req === 1'b0, "R2",
              "reset state", {29'd0, req_ready, resp_valid, fill_req}, 32'd4);

        // R7 and R8: back-to-back replay; 2 then 3 hits in the cycle the refill ends.
        foreach (seq[i]) begin
            access(32'(seq[i]), 2'(i), h);
            if (i == 1)
                check(h, "R8", "same-line follow-up hit", {31'd0, h}, 32'd1);
        end
        check(hits == 4, "R7", "hit count over sequence", 32'(hits), 32'd4);

        // R3: differing only in the top tag bit must miss, then hit.
        access(32'd2, 2'd1, h);
        access(32'd2 | (32'd1 << 29), 2'd3, h);
        check(!h, "R3", "top tag bit mismatch misses", {31'd0, h}, 32'd0);
        access(32'd2 | (32'd1 << 29), 2'd2, h);
        check(h, "R3", "full tag hit", {31'd0, h}, 32'd1);
        access(32'd2, 2'd0, h);
        check(!h, "R7", "evicted tag misses", {31'd0, h}, 32'd0);

        // R2: reset mid-run empties every line.
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ref_valid.delete();
        ref_tag.delete();
        access(32'd3, 2'd0, h);
        check(!h, "R2", "first access after reset misses", {31'd0, h}, 32'd0);
        access(32'd1, 2'd0, h);
        check(h, "R8", "follow-up after refill hits", {31'd0, h}, 32'd1);

        @(negedge clk);
        finish_run();
    end

endmodule